// File: doc/BRIEF.md
# Serial PHY Management Frame Master

This block runs register transactions against Ethernet PHYs over the two-wire management bus: a clock it generates and a shared data line. The host side places one request at a time (direction, 5-bit PHY address, 5-bit register address and, for a write, 16 bits of data). The block serialises the frame, turns the data line around on reads, checks the PHY's acknowledge and returns the read word with a one-cycle completion pulse. The pad buffer stays outside the block. The block gives a data value and an enable for it, and it takes the pad's input back.

The state machine has nine named states. ST_IDLE waits for a request. ST_PRE clocks 32 bits with the data line held high. ST_SEND shifts out the header, and on a write it also shifts out the turnaround and the data. On a read, ST_TURN is the released idle bit and ST_ACK samples the acknowledge. After that the machine moves to ST_RDATA, which captures 16 bits, or to ST_RDUMMY, which clocks 16 bits and discards them. ST_END is the trailing idle bit. ST_FIN raises the completion pulse.

The transitions are as follows:
- IDLE goes to PRE when a request arrives, or straight to FIN for a blocked read.
- PRE goes to SEND after its last bit.
- SEND goes to END on a write, or to TURN on a read.
- TURN goes to ACK.
- ACK goes to RDATA or to RDUMMY.
- RDATA and RDUMMY go to END after 16 bits.
- END goes to FIN.
- FIN returns to IDLE.

Each half-period of the management clock lasts `half_div`+1 system cycles. A single-PHY strap turns away reads aimed at any PHY address other than 0.

Top module: `mdio_master`

## Requirements
- R1: Each transaction that is not blocked opens with 32 management clock periods with the data output enabled and high.
- R2: After the opening bits, 14 bits go out MSB first: start code 01, then the opcode (10 for read, 01 for write), then the 5-bit PHY address, then the 5-bit register address.
- R3: A write follows the register address with the turnaround pattern 10 and then the 16 data bits MSB first, all driven. A write therefore drives 65 bits, counting its trailing idle bit.
- R4: A read disables the data output after the register address and spends one idle bit. It then samples one acknowledge bit, where low means acknowledged. On acknowledge it captures 16 data bits MSB first, each sampled just before the rising clock edge. Read data appears on `rd_data` at the completion pulse.
- R5: When the acknowledge bit is high, the read still clocks 16 further periods. It then completes with `nack`=1 and `rd_data`=0.
- R6: Every transaction ends with one idle clock period. The data output enable is low whenever the block is idle, and a read drives exactly 46 bits.
- R7: With `single_phy`=1, a read to a PHY address other than 0 completes with `done` one cycle after acceptance, with zero data, `nack`=0 and no clock edges. Writes to any address and reads to address 0 proceed normally.
- R8: Each clock half-period lasts `half_div`+1 system cycles, so a full transaction keeps the clock high for 65×(`half_div`+1) cycles. The clock rests low when idle. While driven, the data output changes only at falling clock edges.
- R9: A request is taken only in the idle state. `busy` rises in the cycle after acceptance and stays high through the one-cycle `done` pulse, then drops. A request made while busy has no effect.
- R10: After reset, `busy`, `done`, `mdc`, `mdo_en`, `nack` and `rd_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Transaction request, taken while idle |
| wr | input | 1 | 1 = register write, 0 = register read |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Target register address |
| wr_data | input | 16 | Write data |
| half_div | input | DIV_W | Clock half-period minus one, in system cycles |
| single_phy | input | 1 | Turn away reads to PHY addresses other than 0 |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Read result, valid at `done` |
| nack | output | 1 | Read not acknowledged, valid at `done` |
| mdc | output | 1 | Management clock |
| mdo | output | 1 | Data value to the pad |
| mdo_en | output | 1 | Output enable for the data pad |
| mdi | input | 1 | Data value from the pad |

## Verification
A bit counter that reloads wrongly, or a wrong state branch, shows up as an edge count other than 65 or 0 at the next `done` pulse. A read will also drive a number of bits other than 46. These errors appear within the transaction that caused them. A shifter fault shows up as a header or write frame that no longer matches what the PHY model captured, or as read data shifted by one bit. A divider fault changes the measured high time of the clock in the same transaction. A stuck acknowledge state either sets `nack` on a good read or returns data on a refused one.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int ADDR_W    = 5;
    localparam int DATA_W    = 16;
    localparam int PRE_BITS  = 32;
    localparam int HDR_BITS  = 4 + 2 * ADDR_W;
    localparam int WR_BITS   = HDR_BITS + 2 + DATA_W;
    localparam int CNT_W     = $clog2(WR_BITS);
    localparam logic [1:0] CODE_START = 2'b01;
    localparam logic [1:0] CODE_RD    = 2'b10;
    localparam logic [1:0] CODE_WR    = 2'b01;
    localparam logic [1:0] CODE_TA    = 2'b10;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PRE,
        ST_SEND,
        ST_TURN,
        ST_ACK,
        ST_RDATA,
        ST_RDUMMY,
        ST_END,
        ST_FIN
    } mdio_state_t;
endpackage

// File: rtl/mdio_tick.sv
module mdio_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] half_div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = en && (cnt_q == half_div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt_q <= '0;
        else if (!en || tick) cnt_q <= '0;
        else                 cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/mdio_shift.sv
module mdio_shift #(
    parameter int TX_W = 32,
    parameter int RX_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [TX_W-1:0] load_val,
    input  logic            tx_step,
    input  logic            rx_step,
    input  logic            rx_bit,
    output logic            tx_msb,
    output logic [RX_W-1:0] rx_word
);
    logic [TX_W-1:0] tx_q;
    logic [RX_W-1:0] rx_q;

    assign tx_msb  = tx_q[TX_W-1];
    assign rx_word = rx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '0;
            rx_q <= '0;
        end else if (load) begin
            tx_q <= load_val;
            rx_q <= '0;
        end else begin
            if (tx_step) tx_q <= {tx_q[TX_W-2:0], 1'b0};
            if (rx_step) rx_q <= {rx_q[RX_W-2:0], rx_bit};
        end
    end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req,
    input  logic                  wr,
    input  logic [ADDR_W-1:0]     phy_addr,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [DIV_W-1:0]      half_div,
    input  logic                  single_phy,
    output logic                  busy,
    output logic                  done,
    output logic [DATA_W-1:0]     rd_data,
    output logic                  nack,
    output logic                  mdc,
    output logic                  mdo,
    output logic                  mdo_en,
    input  logic                  mdi
);
    mdio_state_t      state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             mdc_q, is_wr_q, nack_q;
    logic             tick, active, bit_end, rise, last, accept, blocked;
    logic             tx_msb;
    logic [WR_BITS-1:0] frame;

    assign active  = (state_q != ST_IDLE) && (state_q != ST_FIN);
    assign bit_end = tick && mdc_q;
    assign rise    = tick && !mdc_q;
    assign last    = (cnt_q == '0);
    assign accept  = (state_q == ST_IDLE) && req;
    assign blocked = single_phy && !wr && (phy_addr != '0);
    assign frame   = wr ? {CODE_START, CODE_WR, phy_addr, reg_addr, CODE_TA, wr_data}
                        : {CODE_START, CODE_RD, phy_addr, reg_addr, {(WR_BITS-HDR_BITS){1'b0}}};

    mdio_tick #(.DIV_W(DIV_W)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (active),
        .half_div (half_div),
        .tick     (tick)
    );

    mdio_shift #(.TX_W(WR_BITS), .RX_W(DATA_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (frame),
        .tx_step  (bit_end && (state_q == ST_SEND)),
        .rx_step  (rise && (state_q == ST_RDATA)),
        .rx_bit   (mdi),
        .tx_msb   (tx_msb),
        .rx_word  (rd_data)
    );

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req) state_d = blocked ? ST_FIN : ST_PRE;
            ST_PRE:    if (bit_end && last) state_d = ST_SEND;
            ST_SEND:   if (bit_end && last) state_d = is_wr_q ? ST_END : ST_TURN;
            ST_TURN:   if (bit_end) state_d = ST_ACK;
            ST_ACK:    if (bit_end) state_d = nack_q ? ST_RDUMMY : ST_RDATA;
            ST_RDATA,
            ST_RDUMMY: if (bit_end && last) state_d = ST_END;
            ST_END:    if (bit_end) state_d = ST_FIN;
            ST_FIN:    state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // bit counter, clock phase, latched request attributes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            mdc_q   <= 1'b0;
            is_wr_q <= 1'b0;
            nack_q  <= 1'b0;
        end else begin
            if (accept) begin
                cnt_q   <= CNT_W'(PRE_BITS - 1);
                is_wr_q <= wr;
                nack_q  <= 1'b0;
            end else if (bit_end) begin
                if (state_d != state_q) begin
                    unique case (state_d)
                        ST_SEND:   cnt_q <= is_wr_q ? CNT_W'(WR_BITS - 1) : CNT_W'(HDR_BITS - 1);
                        ST_RDATA,
                        ST_RDUMMY: cnt_q <= CNT_W'(DATA_W - 1);
                        default:   cnt_q <= '0;
                    endcase
                end else if (!last) begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
            if (!active)   mdc_q <= 1'b0;
            else if (tick) mdc_q <= !mdc_q;
            if (rise && (state_q == ST_ACK)) nack_q <= mdi;
        end
    end

    // outputs decoded from state
    always_comb begin
        busy   = (state_q != ST_IDLE);
        done   = (state_q == ST_FIN);
        nack   = nack_q;
        mdc    = mdc_q;
        mdo_en = (state_q == ST_PRE) || (state_q == ST_SEND) || ((state_q == ST_END) && is_wr_q);
        mdo    = (state_q == ST_PRE) || ((state_q == ST_SEND) && tx_msb);
    end
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req,
    input logic        busy,
    input logic        done,
    input logic [15:0] rd_data,
    input logic        nack,
    input logic        mdc,
    input logic        mdo,
    input logic        mdo_en
);
    // R6, R8: quiet bus while idle
    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdo_en));

    // R9: acceptance raises busy
    a_r9_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !busy) |=> busy);

    // R9: done is a single pulse inside busy, followed by idle
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    a_r9_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    // R8: driven data only moves when the clock falls
    a_r8_mdo_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (mdo_en && $past(mdo_en) && !$fell(mdc)) |-> $stable(mdo));

    // R5: a refused read returns zero
    a_r5_nack_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && nack) |-> (rd_data == 16'h0000));

    // R8: a transaction starts with the clock low
    a_r8_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !mdc);
endmodule

bind mdio_master mdio_master_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req),
    .busy    (busy),
    .done    (done),
    .rd_data (rd_data),
    .nack    (nack),
    .mdc     (mdc),
    .mdo     (mdo),
    .mdo_en  (mdo_en)
);

// File: tb/mdio_master_test.sv
module mdio_master_test;
    localparam int DIV_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0, wr = 1'b0, single_phy = 1'b0, mdi = 1'b1;
    logic [4:0] phy_addr = '0, reg_addr = '0;
    logic [15:0] wr_data = '0;
    logic [DIV_W-1:0] half_div = '0;
    logic busy, done, nack, mdc, mdo, mdo_en;
    logic [15:0] rd_data;

    always #4 clk = !clk;

    mdio_master #(.DIV_W(DIV_W)) uut (
        .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .phy_addr(phy_addr),
        .reg_addr(reg_addr), .wr_data(wr_data), .half_div(half_div),
        .single_phy(single_phy), .busy(busy), .done(done), .rd_data(rd_data),
        .nack(nack), .mdc(mdc), .mdo(mdo), .mdo_en(mdo_en), .mdi(mdi)
    );

    int n_chk = 0, n_fail = 0;
    bit over = 0;

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // PHY model state
    int unsigned rises = 0, drv = 0, hi_cyc = 0;
    int unsigned base_r = 0, base_d = 0, base_h = 0;
    logic [63:0] cap = '0;
    bit phy_ack = 1;
    logic [15:0] phy_word = '0;

    always @(posedge mdc) begin
        rises++;
        if (mdo_en) begin
            cap = {cap[62:0], mdo};
            drv++;
        end
    end

    always @(negedge mdc) begin
        int unsigned n;
        n = rises - base_r;
        if (n == 47)                mdi = phy_ack ? 1'b0 : 1'b1;
        else if (n >= 48 && n < 64) mdi = phy_word[63 - n];
        else                        mdi = 1'b1;
    end

    always @(negedge clk) if (mdc) hi_cyc++;

    typedef struct {
        bit          blk;
        bit          is_wr;
        logic [15:0] rd;
        bit          nk;
        int unsigned edges;
        int unsigned drv_bits;
        int unsigned hi;
        logic [31:0] frame;
    } exp_t;
    exp_t q[$];

    // monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (done) begin
                if (q.size() == 0) begin
                    chk(0, "R9", "unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(busy == 1'b1, "R9", "busy at done", busy, 1);
                    chk(rd_data == e.rd, e.nk ? "R5" : "R4", "rd_data", rd_data, e.rd);
                    chk(nack == e.nk, "R5", "nack", nack, e.nk);
                    chk(rises - base_r == e.edges, e.blk ? "R7" : "R6", "clock edges", rises - base_r, e.edges);
                    chk(drv - base_d == e.drv_bits, e.is_wr ? "R3" : "R6", "driven bits", drv - base_d, e.drv_bits);
                    chk(hi_cyc - base_h == e.hi, "R8", "mdc high cycles", hi_cyc - base_h, e.hi);
                    if (!e.blk && e.is_wr) begin
                        chk(cap[32:1] == e.frame, "R3", "write frame", cap[32:1], e.frame);
                        chk(cap[63:33] == 31'h7FFF_FFFF, "R1", "preamble", cap[63:33], 31'h7FFF_FFFF);
                    end else if (!e.blk) begin
                        chk(cap[13:0] == e.frame[31:18], "R2", "read header", cap[13:0], e.frame[31:18]);
                        chk(cap[45:14] == 32'hFFFF_FFFF, "R1", "preamble", cap[45:14], 32'hFFFF_FFFF);
                    end
                end
            end
        end
    end

    // driver
    task automatic run(input bit w, input logic [4:0] pa, input logic [4:0] ra,
                       input logic [15:0] wd, input int d, input bit sp,
                       input bit ack, input logic [15:0] word, input bit glitch);
        exp_t e;
        bit blk;
        int cyc;
        blk = sp && !w && (pa != 0);
        e.blk = blk;
        e.is_wr = w;
        e.nk = !blk && !w && !ack;
        e.rd = (blk || w || !ack) ? 16'h0 : word;
        e.edges = blk ? 0 : 65;
        e.drv_bits = blk ? 0 : (w ? 65 : 46);
        e.hi = blk ? 0 : 65 * (d + 1);
        e.frame = w ? {2'b01, 2'b01, pa, ra, 2'b10, wd} : {2'b01, 2'b10, pa, ra, 18'h0};
        q.push_back(e);
        @(negedge clk);
        base_r = rises; base_d = drv; base_h = hi_cyc;
        phy_ack = ack; phy_word = word;
        wr = w; phy_addr = pa; reg_addr = ra; wr_data = wd;
        half_div = DIV_W'(d); single_phy = sp; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        chk(busy == 1'b1, "R9", "busy after accept", busy, 1);
        cyc = 0;
        while (!done && cyc < 20000) begin
            if (glitch && cyc == 20) begin
                req = 1'b1; wr = !w; phy_addr = pa ^ 5'h1F; reg_addr = ra ^ 5'h15; wr_data = ~wd;
            end
            if (glitch && cyc == 21) req = 1'b0;
            @(negedge clk);
            cyc++;
        end
        chk(done == 1'b1, "R9", "done seen", done, 1);
        if (blk) chk(cyc == 0, "R7", "blocked latency", cyc, 0);
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R9", "idle after done", {busy, done}, 0);
        if (glitch) begin
            repeat (10) @(negedge clk);
            chk(busy == 1'b0 && done == 1'b0, "R9", "no extra transaction", {busy, done}, 0);
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk({busy, done, mdc, mdo_en, nack} == 5'b0 && rd_data == 16'h0, "R10", "reset outputs",
            {busy, done, mdc, mdo_en, nack, rd_data}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        run(1, 5'd3,  5'h11, 16'hA5C3, 1, 0, 1, 16'h0,    0); // R1 R2 R3 R8
        run(0, 5'd9,  5'h02, 16'h0,    0, 0, 1, 16'h5A0F, 0); // R4
        run(0, 5'd1,  5'h1F, 16'h0,    2, 0, 0, 16'hFFFF, 0); // R5
        run(0, 5'd0,  5'h05, 16'h0,    0, 1, 1, 16'hFFFF, 0); // R7 address 0 allowed
        run(0, 5'd5,  5'h05, 16'h0,    0, 1, 1, 16'h1234, 0); // R7 blocked
        run(1, 5'd5,  5'h0A, 16'h0001, 0, 1, 1, 16'h0,    0); // R7 writes pass
        run(0, 5'd31, 5'h00, 16'h0,    3, 0, 1, 16'h8000, 0); // R4 MSB
        run(0, 5'd2,  5'h01, 16'h0,    0, 0, 1, 16'h0001, 0); // R4 LSB
        run(1, 5'd17, 5'h1E, 16'h8001, 1, 0, 1, 16'h0,    1); // R9 request while busy
        run(0, 5'd4,  5'h07, 16'h0,    1, 0, 1, 16'hC33C, 1); // R9 request while busy
        chk(q.size() == 0, "R9", "scoreboard drained", q.size(), 0);
        over = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!over) begin
            n_chk++;
            n_fail++;
            $display("FAIL R9 watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule